// File: doc/BRIEF.md
# Interrupting Control and Status Register Bank

This block holds the host-visible control and status registers of a network-style DMA engine. The host reaches four 16-bit registers through two bus locations. Offset 4 is a select port that picks a register. Offset 0 is a data port that reads or writes the selected register. Register 0 is the live control and status word:

- Status bits are set by one-cycle pulses from the datapath and cleared by the host.
- Command bits can only be set by the host, and follow fixed precedence rules.
- An interrupt enable bit is read/write.
- Two summary bits are derived from the live status.

Registers 1 to 3 are plain storage that the datapath can use for configuration.

The block also drives a level interrupt line and two engine-enable outputs. The datapath asks for the receive and transmit engines to run through a two-bit level input. The block reports and forwards that request unless a memory error is pending.

Top module: `csr_irq_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x0004 (only the stop command, bit 2, set, with the engine request low), the select register reads 0, registers 1 to 3 read 0, and the interrupt output is low.
- R2: Status bits 14 (babble), 13 (collision error), 12 (missed frame), 11 (memory error), 10 (receive done), 9 (transmit done) and 8 (init done) are set by `statusSet[6:0]` (bit i of the input maps to register bit 8+i). Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged.
- R3: Writing 1 to bit 3 (transmit demand) sets it. Writing 1 to bit 1 (start) sets start and clears stop. Writing 1 to bit 0 (init) sets init and clears stop. Writing 0 never clears any of these bits.
- R4: Writing 1 to bit 2 (stop) sets stop and clears start and init, even when start or init is also written as 1 in the same write.
- R5: Bit 6 (interrupt enable) takes the written value, 0 or 1.
- R6: Bit 15 reads as babble OR collision OR missed OR memory error. Bit 7 reads as babble OR missed OR memory error OR receive done OR transmit done OR init done.
- R7: Bits 5 (receive on) and 4 (transmit on), and the outputs `rxEnable` and `txEnable`, follow `engineReq[1]` and `engineReq[0]`, but read as 0 while the memory error bit is set.
- R8: While stop is set, init done is held at 0, and a set pulse for it has no effect.
- R9: `irq` is high exactly when bit 7 and bit 6 are both set.
- R10: A write to offset 4 keeps the low 2 bits as the select value, which reads back at offset 4 in bits 1:0 with 0 above. `selOutOfRange` is high after a select write whose value exceeds 3, and low after one that does not.
- R11: When a set pulse and a host write-one-to-clear hit the same status bit in the same cycle, the bit ends up set (subject to R8).
- R12: Writes at offset 0 with select 1, 2 or 3 store the full word in that register. Accesses at offsets other than 0 and 4 change nothing and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the current bus access |
| busOffset | input | 3 | Byte offset of the access: 0 data port, 4 select port |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed location (combinational) |
| statusSet | input | 7 | One-cycle set pulses for status bits 14..8 |
| engineReq | input | 2 | Datapath request: bit 1 receive, bit 0 transmit |
| rxEnable | output | 1 | Receive engine enabled |
| txEnable | output | 1 | Transmit engine enabled |
| cmdStart | output | 1 | Start command bit |
| cmdStop | output | 1 | Stop command bit |
| cmdInit | output | 1 | Init command bit |
| cmdTxDemand | output | 1 | Transmit demand command bit |
| selOutOfRange | output | 1 | Last select write exceeded 3 |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 16-bit word and four registers, so the select field is 2 bits wide. With those values, every select value above 3 that fits in the written word is reachable, so the out-of-range flag and the low-bit truncation are both exercised. The set-only command bits, the clear-on-write status bits and the summary and gating bits all share one word. Random writes therefore cross them with one another and with sparse status pulses in every combination, including a clear that meets a set in the same cycle.

// File: rtl/csr_irq_pkg.sv
`timescale 1ns/1ps
package csr_irq_pkg;
  localparam int STAT_N    = 7;   // status bits occupy 14..8
  localparam int STAT_LO   = 8;
  localparam int BIT_ERR   = 15;
  localparam int BIT_INTR  = 7;
  localparam int BIT_IEN   = 6;
  localparam int BIT_RXON  = 5;
  localparam int BIT_TXON  = 4;
  localparam int BIT_TDMD  = 3;
  localparam int BIT_STOP  = 2;
  localparam int BIT_START = 1;
  localparam int BIT_INIT  = 0;
  // index of memory-error and init-done inside the status vector
  localparam int ST_MEMERR = 3;
  localparam int ST_IDONE  = 0;

  typedef struct packed {
    logic wrData;   // write to the data port
    logic wrSel;    // write to the select port
    logic isData;   // access addresses the data port
    logic isSel;    // access addresses the select port
  } busStrobe_t;
endpackage

// File: rtl/csr_bus_ctl.sv
`timescale 1ns/1ps
module csr_bus_ctl
  import csr_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [2:0]        busOffset,
  input  logic [DATA_W-1:0] busWdata,
  output busStrobe_t        strobe,
  output logic [SEL_W-1:0]  selQ,
  output logic              selBadQ
);
  always_comb begin
    strobe.isData = (busOffset == 3'd0);
    strobe.isSel  = (busOffset == 3'd4);
    strobe.wrData = busWr && strobe.isData;
    strobe.wrSel  = busWr && strobe.isSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= '0;
      selBadQ <= 1'b0;
    end else if (strobe.wrSel) begin
      selQ    <= busWdata[SEL_W-1:0];
      selBadQ <= (busWdata > DATA_W'(NUM_REGS - 1));
    end
  end

  assert_sel_keep_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSel |=> selQ == $past(busWdata[SEL_W-1:0]));
  assert_sel_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrSel && busWdata[DATA_W-1:SEL_W] == '0) |=> !selBadQ);
endmodule

// File: rtl/csr_status_dp.sv
`timescale 1ns/1ps
module csr_status_dp
  import csr_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [SEL_W-1:0]  selQ,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [STAT_N-1:0] statusSet,
  input  logic [1:0]        engineReq,
  output logic [DATA_W-1:0] dataRd,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              cmdStart,
  output logic              cmdStop,
  output logic              cmdInit,
  output logic              cmdTxDemand,
  output logic              irq
);
  logic [STAT_N-1:0] statusQ, statusN;
  logic intEnQ, tdmdQ, stopQ, startQ, initQ;
  logic stopN, startN, initN;
  logic wrMain, errSum, intSum;
  logic [DATA_W-1:0] mainView;
  logic [DATA_W-1:0] auxQ [1:NUM_REGS-1];

  assign wrMain = strobe.wrData && (selQ == '0);

  always_comb begin
    stopN  = stopQ;
    startN = startQ;
    initN  = initQ;
    if (wrMain) begin
      if (wrWord[BIT_START]) begin startN = 1'b1; stopN = 1'b0; end
      if (wrWord[BIT_INIT])  begin initN  = 1'b1; stopN = 1'b0; end
      if (wrWord[BIT_STOP])  begin stopN = 1'b1; startN = 1'b0; initN = 1'b0; end
    end
    for (int i = 0; i < STAT_N; i++)
      statusN[i] = statusSet[i] | (statusQ[i] & ~(wrMain & wrWord[STAT_LO+i]));
    if (stopN) statusN[ST_IDONE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      intEnQ  <= 1'b0;
      tdmdQ   <= 1'b0;
      stopQ   <= 1'b1;
      startQ  <= 1'b0;
      initQ   <= 1'b0;
    end else begin
      statusQ <= statusN;
      stopQ   <= stopN;
      startQ  <= startN;
      initQ   <= initN;
      if (wrMain) begin
        intEnQ <= wrWord[BIT_IEN];
        if (wrWord[BIT_TDMD]) tdmdQ <= 1'b1;
      end
    end
  end

  for (genvar k = 1; k < NUM_REGS; k++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rstN)                                        auxQ[k] <= '0;
      else if (strobe.wrData && selQ == SEL_W'(k))      auxQ[k] <= wrWord;
    end
  end

  always_comb begin
    errSum   = statusQ[6] | statusQ[5] | statusQ[4] | statusQ[3];
    intSum   = statusQ[6] | statusQ[4] | statusQ[3] | statusQ[2] | statusQ[1] | statusQ[0];
    rxEnable = engineReq[1] & ~statusQ[ST_MEMERR];
    txEnable = engineReq[0] & ~statusQ[ST_MEMERR];
    mainView = '0;
    mainView[BIT_ERR]                  = errSum;
    mainView[STAT_LO+STAT_N-1:STAT_LO] = statusQ;
    mainView[BIT_INTR]  = intSum;
    mainView[BIT_IEN]   = intEnQ;
    mainView[BIT_RXON]  = rxEnable;
    mainView[BIT_TXON]  = txEnable;
    mainView[BIT_TDMD]  = tdmdQ;
    mainView[BIT_STOP]  = stopQ;
    mainView[BIT_START] = startQ;
    mainView[BIT_INIT]  = initQ;
    dataRd = (selQ == '0) ? mainView : auxQ[selQ];
  end

  assign irq         = intSum & intEnQ;
  assign cmdStart    = startQ;
  assign cmdStop     = stopQ;
  assign cmdInit     = initQ;
  assign cmdTxDemand = tdmdQ;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (stopQ && !startQ && !initQ && !tdmdQ && !intEnQ && statusQ == '0));
  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrMain && wrWord[BIT_STOP]) |=> (stopQ && !startQ && !initQ));
  assert_idone_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopQ |-> !statusQ[ST_IDONE]);
  assert_merr_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[ST_MEMERR] |-> (!rxEnable && !txEnable));
  for (genvar i = 0; i < STAT_N; i++) begin : g_chk
    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rstN)
      (wrMain && wrWord[STAT_LO+i] && !statusSet[i]) |=> !statusQ[i]);
    if (i != ST_IDONE) begin : g_set
      assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
        statusSet[i] |=> statusQ[i]);
    end
  end
endmodule

// File: rtl/csr_irq_ctrl.sv
`timescale 1ns/1ps
module csr_irq_ctrl
  import csr_irq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [2:0]        busOffset,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [6:0]        statusSet,
  input  logic [1:0]        engineReq,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              cmdStart,
  output logic              cmdStop,
  output logic              cmdInit,
  output logic              cmdTxDemand,
  output logic              selOutOfRange,
  output logic              irq
);
  localparam int SEL_W = $clog2(NUM_REGS);

  busStrobe_t        strobe;
  logic [SEL_W-1:0]  selQ;
  logic [DATA_W-1:0] dataRd;

  csr_bus_ctl #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_ctl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busOffset(busOffset),
    .busWdata(busWdata), .strobe(strobe), .selQ(selQ), .selBadQ(selOutOfRange));

  csr_status_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selQ(selQ), .wrWord(busWdata),
    .statusSet(statusSet), .engineReq(engineReq), .dataRd(dataRd),
    .rxEnable(rxEnable), .txEnable(txEnable), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdInit(cmdInit), .cmdTxDemand(cmdTxDemand), .irq(irq));

  always_comb begin
    if (strobe.isData)     busRdata = dataRd;
    else if (strobe.isSel) busRdata = DATA_W'(selQ);
    else                   busRdata = '0;
  end
endmodule

// File: tb/tb_csr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_csr_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [2:0] busOffset = 3'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic [6:0] statusSet = 7'd0;
  logic [1:0] engineReq = 2'd0;
  logic rxEnable, txEnable, cmdStart, cmdStop, cmdInit, cmdTxDemand, selOutOfRange, irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // bench model
  logic [6:0]  mStatus;
  logic        mIntEn, mTdmd, mStop, mStart, mInit, mSelBad;
  logic [1:0]  mSel;
  logic [15:0] mAux [1:3];

  always #2 clk = ~clk;  // 250 MHz

  csr_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busOffset(busOffset), .busWdata(busWdata),
    .busRdata(busRdata), .statusSet(statusSet), .engineReq(engineReq),
    .rxEnable(rxEnable), .txEnable(txEnable), .cmdStart(cmdStart), .cmdStop(cmdStop),
    .cmdInit(cmdInit), .cmdTxDemand(cmdTxDemand), .selOutOfRange(selOutOfRange), .irq(irq));

  function automatic logic expIntr();
    return mStatus[6] | mStatus[4] | mStatus[3] | mStatus[2] | mStatus[1] | mStatus[0];
  endfunction

  function automatic logic [15:0] expRead(logic [2:0] off, logic [1:0] eng);
    logic err;
    if (off == 3'd4) return {14'd0, mSel};
    if (off != 3'd0) return 16'd0;
    if (mSel != 2'd0) return mAux[mSel];
    err = mStatus[6] | mStatus[5] | mStatus[4] | mStatus[3];
    return {err, mStatus, expIntr(), mIntEn, eng[1] & ~mStatus[3], eng[0] & ~mStatus[3],
            mTdmd, mStop, mStart, mInit};
  endfunction

  task automatic modelReset();
    mStatus = '0; mIntEn = 0; mTdmd = 0; mStop = 1; mStart = 0; mInit = 0;
    mSel = 0; mSelBad = 0;
    for (int k = 1; k < 4; k++) mAux[k] = '0;
  endtask

  task automatic modelClock(logic wr, logic [2:0] off, logic [15:0] wd, logic [6:0] ev);
    logic wrMain;
    wrMain = wr && off == 3'd0 && mSel == 2'd0;
    for (int i = 0; i < 7; i++)
      mStatus[i] = ev[i] | (mStatus[i] & ~(wrMain & wd[8+i]));
    if (wrMain) begin
      if (wd[1]) begin mStart = 1; mStop = 0; end
      if (wd[0]) begin mInit = 1; mStop = 0; end
      if (wd[2]) begin mStop = 1; mStart = 0; mInit = 0; end
      if (wd[3]) mTdmd = 1;
      mIntEn = wd[6];
    end else if (wr && off == 3'd0) begin
      mAux[mSel] = wd;
    end
    if (mStop) mStatus[0] = 1'b0;
    if (wr && off == 3'd4) begin
      mSel = wd[1:0];
      mSelBad = (wd > 16'd3);
    end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle: apply at negedge, check combinational view, then clock the model
  task automatic step(logic wr, logic [2:0] off, logic [15:0] wd, logic [6:0] ev, logic [1:0] eng);
    busWr = wr; busOffset = off; busWdata = wd; statusSet = ev; engineReq = eng;
    #1;
    chk("R6/R12 read data", busRdata, expRead(off, eng));
    chk("R9 irq", {15'd0, irq}, {15'd0, expIntr() & mIntEn});
    chk("R7 engine enables", {14'd0, rxEnable, txEnable},
        {14'd0, eng[1] & ~mStatus[3], eng[0] & ~mStatus[3]});
    chk("R10 select flag", {15'd0, selOutOfRange}, {15'd0, mSelBad});
    chk("R3 command outputs", {12'd0, cmdTxDemand, cmdStop, cmdStart, cmdInit},
        {12'd0, mTdmd, mStop, mStart, mInit});
    @(posedge clk);
    modelClock(wr, off, wd, ev);
    @(negedge clk);
  endtask

  task automatic idle(logic [2:0] off, logic [1:0] eng);
    step(1'b0, off, 16'd0, 7'd0, eng);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busOffset = 3'd0; #1;
    chk("R1 reg0 after reset", busRdata, 16'h0004);
    busOffset = 3'd4; #1;
    chk("R1 select after reset", busRdata, 16'h0000);
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    @(negedge clk);

    // R4: stop wins over start and init in one write
    step(1, 3'd0, 16'h0003, 7'd0, 2'b00);
    idle(3'd0, 2'b00);
    chk("R3 start/init clear stop", busRdata & 16'h0007, 16'h0003);
    step(1, 3'd0, 16'h0007, 7'd0, 2'b00);
    idle(3'd0, 2'b00);
    chk("R4 stop precedence", busRdata & 16'h0007, 16'h0004);

    // R8: init done ignored while stopped
    step(0, 3'd0, 16'h0000, 7'h01, 2'b00);
    chk("R8 idone held while stopped", busRdata & 16'h0100, 16'h0000);

    // R3: start, then demand; zeros do not clear
    step(1, 3'd0, 16'h000A, 7'd0, 2'b00);
    step(1, 3'd0, 16'h0000, 7'd0, 2'b00);
    chk("R3 set-only bits survive zero write", busRdata & 16'h000F, 16'h000A);

    // R2 / R6: set all status, then clear with set on rx done (R11)
    step(0, 3'd0, 16'h0000, 7'h7F, 2'b11);
    chk("R6 summaries all set", busRdata & 16'hFF80, 16'hFF80);
    chk("R7 memerr gates engines", {14'd0, rxEnable, txEnable}, 16'd0);
    step(1, 3'd0, 16'h7F00, 7'h04, 2'b11);
    chk("R11 set beats clear", busRdata & 16'hFF80, 16'h0480);
    chk("R7 engines back on", {14'd0, rxEnable, txEnable}, 16'h0003);
    step(1, 3'd0, 16'h0000, 7'h00, 2'b11);
    chk("R2 zero write keeps status", busRdata & 16'h0400, 16'h0400);

    // R5 / R9: interrupt enable
    step(1, 3'd0, 16'h0040, 7'd0, 2'b00);
    chk("R9 irq with enable", {15'd0, irq}, 16'd1);
    step(1, 3'd0, 16'h0400, 7'd0, 2'b00);
    chk("R5 enable cleared by zero", busRdata & 16'h0040, 16'h0000);
    chk("R9 irq drops", {15'd0, irq}, 16'd0);

    // R10 / R12: select and aux storage
    step(1, 3'd4, 16'h0007, 7'd0, 2'b00);
    chk("R10 select truncated", busRdata, 16'h0003);
    chk("R10 out of range flag", {15'd0, selOutOfRange}, 16'd1);
    step(1, 3'd0, 16'hBEEF, 7'd0, 2'b00);
    step(1, 3'd2, 16'h1234, 7'd0, 2'b00);
    chk("R12 other offset reads 0", busRdata, 16'h0000);
    idle(3'd0, 2'b00);
    chk("R12 aux stored", busRdata, 16'hBEEF);
    step(1, 3'd4, 16'h0001, 7'd0, 2'b00);
    chk("R10 flag clears", {15'd0, selOutOfRange}, 16'd0);
    step(1, 3'd4, 16'h0000, 7'd0, 2'b00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] off;
      logic [15:0] wd;
      logic [6:0] ev;
      int r;
      r = $urandom % 16;
      off = (r < 10) ? 3'd0 : (r < 14) ? 3'd4 : 3'($urandom % 8);
      wd = 16'($urandom);
      if (off == 3'd4 && ($urandom % 4) != 0) wd = 16'($urandom % 4);
      for (int i = 0; i < 7; i++) ev[i] = (($urandom % 8) == 0);
      step(($urandom % 3) != 0, off, wd, ev, 2'($urandom));
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule